// File: doc/BRIEF.md
# RTC Alarm and Second Control Unit

This block sits beside the timekeeping counters of a real-time clock. It holds three alarm fields (seconds, minutes, hours), each with its own enable bit, and compares them with the live counts each time the seconds count updates. A sticky alarm flag records a match and, gated by an interrupt-enable bit, drives the alarm interrupt.

The block also holds the second control register. This register carries a periodic flag that is set by a selectable tick pulse, the tick selector, a count-enable bit, a start bit, and two self-clearing strobes. One strobe requests a 30-second adjustment and the other resets the prescaler. The counters, prescaler and oscillator sit outside the block. They reach it only as count inputs, tick pulses and the control outputs.

Software reaches the block through a small register bus. Address 0 holds the alarm seconds, address 1 the alarm minutes and address 2 the alarm hours. Each alarm field has its enable in bit 7 and its value in the low bits. Address 3 is the first control register: bit 3 is the alarm interrupt enable and bit 0 is the alarm flag. Address 4 is the second control register. Every other address reads 0.

Top module: `rtc_alarm_ctl`

## Requirements
- R1: After rst_ni the second control register reads 0x09, cnt_en_o and start_o are 1, the alarm fields and the first control register read 0, and both interrupts are 0.
- R2: In a cycle with sec_upd_i high, the alarm flag (address 3, bit 0) becomes 1 on the next cycle if every enabled alarm field equals its count input. A field whose enable bit is 0 plays no part in the comparison.
- R3: The alarm flag never sets while no alarm field is enabled, and it never sets in a cycle without sec_upd_i, even while the counts match.
- R4: Writing 0 to the alarm flag clears it and writing 1 leaves it unchanged. If a match and a clearing write fall in the same cycle, the flag is 1.
- R5: alm_irq_o is 1 exactly when the alarm flag and the alarm interrupt enable (address 3, bit 3) are both 1.
- R6: The second control register has this layout: bit 7 is the periodic flag, bits 6:4 the tick select, bit 3 the count enable, bit 2 the adjust strobe, bit 1 the divider reset strobe and bit 0 the start bit. cnt_en_o follows bit 3 and start_o follows bit 0.
- R7: With tick select n from 1 to 7, a pulse on tick_i[n-1] sets the periodic flag. Tick select 0 never sets it. per_irq_o equals the flag. Writing 0 to the flag clears it and writing 1 leaves it unchanged.
- R8: Writing 1 to bit 2 of the second control register drives adj_o high for exactly the next cycle, and bit 2 always reads 0.
- R9: Writing 1 to bit 1 of the second control register drives div_rst_o high for exactly the next cycle, and bit 1 always reads 0.
- R10: A cycle with mrst_i high clears the first control register and every bit of the second control register except bits 3 and 0, which keep their values. The alarm fields keep their values.
- R11: While stby_i is high the second control register ignores bus writes, tick pulses and mrst_i, and keeps its contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Power-on reset, active low, asynchronous |
| mrst_i | input | 1 | Manual reset, synchronous, one cycle |
| stby_i | input | 1 | Standby hold for the second control register |
| addr_i | input | 3 | Register address |
| we_i | input | 1 | Write enable |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational from addr_i |
| sec_i | input | 7 | Current seconds count |
| min_i | input | 7 | Current minutes count |
| hr_i | input | 6 | Current hours count |
| sec_upd_i | input | 1 | Seconds count updated this cycle |
| tick_i | input | 7 | Prescaler tick pulses, one per select code 1 to 7 |
| alm_irq_o | output | 1 | Alarm interrupt |
| per_irq_o | output | 1 | Periodic interrupt |
| adj_o | output | 1 | 30-second adjust pulse to the counter |
| div_rst_o | output | 1 | Prescaler reset pulse |
| cnt_en_o | output | 1 | Count enable |
| start_o | output | 1 | Count start |

## Verification
The assertions check several rules on every cycle. The alarm flag only rises after a seconds update. A write of 1 never clears the alarm flag. The periodic flag only rises after a tick under a nonzero select. Each strobe output is traced to a write of its bit. A manual reset keeps the run-control bits, and standby freezes the second control register. Two sweeps cover what only scenarios can show. One walks every combination of enable mask and per-field match against the expected flag value. The other walks every tick select against every tick line. The flag-versus-write collisions and the manual-reset and standby sequences are driven as directed cases.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned PES_W  = 3;
  localparam int unsigned NTICK  = (1 << PES_W) - 1;

  localparam logic [ADDR_W-1:0] A_ASEC = 3'd0;
  localparam logic [ADDR_W-1:0] A_AMIN = 3'd1;
  localparam logic [ADDR_W-1:0] A_AHR  = 3'd2;
  localparam logic [ADDR_W-1:0] A_CTL1 = 3'd3;
  localparam logic [ADDR_W-1:0] A_CTL2 = 3'd4;

  // second control register bit positions
  localparam int unsigned C2_PEF  = 7;
  localparam int unsigned C2_PES  = 4;
  localparam int unsigned C2_CEN  = 3;
  localparam int unsigned C2_ADJ  = 2;
  localparam int unsigned C2_DIVR = 1;
  localparam int unsigned C2_ST   = 0;

  // first control register bit positions
  localparam int unsigned C1_AIE = 3;
  localparam int unsigned C1_AF  = 0;
endpackage

// File: rtl/rtc_alarm_field.sv
module rtc_alarm_field
  import rtc_pkg::*;
#(
  parameter int unsigned      W    = 7,
  parameter logic [ADDR_W-1:0] ADDR = A_ASEC
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  input  logic [W-1:0]      cnt_i,
  output logic              en_o,
  output logic              ok_o,
  output logic [7:0]        rd_o
);
  logic         en_q;
  logic [W-1:0] val_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      val_q <= '0;
    end else if (we_i && addr_i == ADDR) begin
      en_q  <= wdata_i[7];
      val_q <= wdata_i[W-1:0];
    end
  end

  assign en_o = en_q;
  assign ok_o = !en_q || (val_q == cnt_i);  // disabled field never blocks a match

  always_comb begin
    rd_o         = '0;
    rd_o[W-1:0]  = val_q;
    rd_o[7]      = en_q;
  end
endmodule

// File: rtl/rtc_alarm_flag.sv
module rtc_alarm_flag
  import rtc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mrst_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  input  logic              sec_upd_i,
  input  logic              match_i,
  output logic              af_o,
  output logic              aie_o
);
  logic af_q, aie_q;
  logic wr;

  assign wr = we_i && addr_i == A_CTL1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      af_q  <= 1'b0;
      aie_q <= 1'b0;
    end else if (mrst_i) begin
      af_q  <= 1'b0;
      aie_q <= 1'b0;
    end else begin
      if (wr) begin
        aie_q <= wdata_i[C1_AIE];
        if (!wdata_i[C1_AF]) af_q <= 1'b0;
      end
      if (sec_upd_i && match_i) af_q <= 1'b1;  // set beats clear
    end
  end

  assign af_o  = af_q;
  assign aie_o = aie_q;
endmodule

// File: rtl/rtc_ctl2.sv
module rtc_ctl2
  import rtc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mrst_i,
  input  logic              stby_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  input  logic [NTICK-1:0]  tick_i,
  output logic              pef_o,
  output logic [PES_W-1:0]  pes_o,
  output logic              cen_o,
  output logic              st_o,
  output logic              adj_o,
  output logic              divr_o,
  output logic [7:0]        rd_o
);
  logic             pef_q, cen_q, st_q, adj_q, divr_q;
  logic [PES_W-1:0] pes_q;
  logic [NTICK:0]   tick_ext;
  logic             tick_hit, wr;

  assign tick_ext = {tick_i, 1'b0};  // code 0 selects a constant 0
  assign tick_hit = tick_ext[pes_q];
  assign wr       = we_i && addr_i == A_CTL2;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pef_q  <= 1'b0;
      pes_q  <= '0;
      cen_q  <= 1'b1;
      st_q   <= 1'b1;
      adj_q  <= 1'b0;
      divr_q <= 1'b0;
    end else begin
      adj_q  <= 1'b0;
      divr_q <= 1'b0;
      if (!stby_i) begin
        if (mrst_i) begin
          pef_q <= 1'b0;
          pes_q <= '0;
        end else begin
          if (wr) begin
            if (!wdata_i[C2_PEF]) pef_q <= 1'b0;
            pes_q  <= wdata_i[C2_PES +: PES_W];
            cen_q  <= wdata_i[C2_CEN];
            st_q   <= wdata_i[C2_ST];
            adj_q  <= wdata_i[C2_ADJ];
            divr_q <= wdata_i[C2_DIVR];
          end
          if (tick_hit) pef_q <= 1'b1;
        end
      end
    end
  end

  assign pef_o  = pef_q;
  assign pes_o  = pes_q;
  assign cen_o  = cen_q;
  assign st_o   = st_q;
  assign adj_o  = adj_q;
  assign divr_o = divr_q;

  always_comb begin
    rd_o                    = '0;
    rd_o[C2_PEF]            = pef_q;
    rd_o[C2_PES +: PES_W]   = pes_q;
    rd_o[C2_CEN]            = cen_q;
    rd_o[C2_ST]             = st_q;
  end
endmodule

// File: rtl/rtc_alarm_ctl.sv
module rtc_alarm_ctl
  import rtc_pkg::*;
#(
  parameter int unsigned SEC_W = 7,
  parameter int unsigned MIN_W = 7,
  parameter int unsigned HR_W  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mrst_i,
  input  logic              stby_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  input  logic [SEC_W-1:0]  sec_i,
  input  logic [MIN_W-1:0]  min_i,
  input  logic [HR_W-1:0]   hr_i,
  input  logic              sec_upd_i,
  input  logic [NTICK-1:0]  tick_i,
  output logic              alm_irq_o,
  output logic              per_irq_o,
  output logic              adj_o,
  output logic              div_rst_o,
  output logic              cnt_en_o,
  output logic              start_o
);
  localparam int unsigned NFLD = 3;

  logic [NFLD-1:0] fld_en, fld_ok;
  logic [7:0]      rd_sec, rd_min, rd_hr, rd_c2;
  logic            match, af, aie, pef;
  logic [PES_W-1:0] pes;

  rtc_alarm_field #(.W(SEC_W), .ADDR(A_ASEC)) u_fsec (
    .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i, .cnt_i(sec_i),
    .en_o(fld_en[0]), .ok_o(fld_ok[0]), .rd_o(rd_sec));
  rtc_alarm_field #(.W(MIN_W), .ADDR(A_AMIN)) u_fmin (
    .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i, .cnt_i(min_i),
    .en_o(fld_en[1]), .ok_o(fld_ok[1]), .rd_o(rd_min));
  rtc_alarm_field #(.W(HR_W), .ADDR(A_AHR)) u_fhr (
    .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i, .cnt_i(hr_i),
    .en_o(fld_en[2]), .ok_o(fld_ok[2]), .rd_o(rd_hr));

  // no enabled field means no alarm
  assign match = (|fld_en) && (&fld_ok);

  rtc_alarm_flag u_flag (
    .clk_i, .rst_ni, .mrst_i, .we_i, .addr_i, .wdata_i,
    .sec_upd_i, .match_i(match), .af_o(af), .aie_o(aie));

  rtc_ctl2 u_ctl2 (
    .clk_i, .rst_ni, .mrst_i, .stby_i, .we_i, .addr_i, .wdata_i, .tick_i,
    .pef_o(pef), .pes_o(pes), .cen_o(cnt_en_o), .st_o(start_o),
    .adj_o(adj_o), .divr_o(div_rst_o), .rd_o(rd_c2));

  assign alm_irq_o = af & aie;
  assign per_irq_o = pef;

  always_comb begin
    unique case (addr_i)
      A_ASEC:  rdata_o = rd_sec;
      A_AMIN:  rdata_o = rd_min;
      A_AHR:   rdata_o = rd_hr;
      A_CTL1:  rdata_o = {4'b0, aie, 2'b0, af};
      A_CTL2:  rdata_o = rd_c2;
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/rtc_alarm_ctl_chk.sv
module rtc_alarm_ctl_chk
  import rtc_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              mrst_i,
  input logic              stby_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              we_i,
  input logic [7:0]        wdata_i,
  input logic              sec_upd_i,
  input logic [NTICK-1:0]  tick_i,
  input logic              af_i,
  input logic              pef_i,
  input logic [PES_W-1:0]  pes_i,
  input logic              adj_o,
  input logic              div_rst_o,
  input logic              cnt_en_o,
  input logic              start_o
);
  logic c2_wr;
  assign c2_wr = we_i && addr_i == A_CTL2 && !stby_i && !mrst_i;

  // R2
  af_after_upd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(af_i) |-> $past(sec_upd_i));

  // R4
  af_write1_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (af_i && we_i && addr_i == A_CTL1 && wdata_i[C1_AF] && !mrst_i) |=> af_i);

  // R7
  pef_after_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pef_i) |-> $past((pes_i != '0) && (|tick_i)));

  // R8
  adj_from_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adj_o |-> $past(c2_wr && wdata_i[C2_ADJ]));

  // R9
  divr_from_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_rst_o |-> $past(c2_wr && wdata_i[C2_DIVR]));

  // R10
  mrst_keep_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mrst_i |=> (cnt_en_o == $past(cnt_en_o)) && (start_o == $past(start_o)));

  // R11
  stby_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stby_i |=> $stable({pef_i, pes_i, cnt_en_o, start_o}));
endmodule

bind rtc_alarm_ctl rtc_alarm_ctl_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .mrst_i(mrst_i), .stby_i(stby_i),
  .addr_i(addr_i), .we_i(we_i), .wdata_i(wdata_i), .sec_upd_i(sec_upd_i),
  .tick_i(tick_i), .af_i(af), .pef_i(pef), .pes_i(pes),
  .adj_o(adj_o), .div_rst_o(div_rst_o), .cnt_en_o(cnt_en_o), .start_o(start_o));

// File: tb/tb_rtc_alarm_ctl.sv
module tb_rtc_alarm_ctl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mrst = 1'b0, stby = 1'b0, we = 1'b0, sec_upd = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic [6:0] sec = '0, min = '0, tick = '0;
  logic [5:0] hr = '0;
  logic       alm_irq, per_irq, adj, div_rst, cnt_en, start;
  int         n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  rtc_alarm_ctl dut (
    .clk_i(clk), .rst_ni(rst_n), .mrst_i(mrst), .stby_i(stby), .addr_i(addr),
    .we_i(we), .wdata_i(wdata), .rdata_o(rdata), .sec_i(sec), .min_i(min),
    .hr_i(hr), .sec_upd_i(sec_upd), .tick_i(tick), .alm_irq_o(alm_irq),
    .per_irq_o(per_irq), .adj_o(adj), .div_rst_o(div_rst), .cnt_en_o(cnt_en),
    .start_o(start));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input string req, input logic [2:0] a, input logic [7:0] exp);
    addr = a; #1; chk(req, rdata, exp);
  endtask

  task automatic upd(input logic [6:0] s, input logic [6:0] m, input logic [5:0] h);
    @(negedge clk); sec = s; min = m; hr = h; sec_upd = 1'b1;
    @(negedge clk); sec_upd = 1'b0;
  endtask

  task automatic tk(input int idx);
    @(negedge clk); tick = 7'(1 << idx);
    @(negedge clk); tick = '0;
  endtask

  task automatic mpulse();
    @(negedge clk); mrst = 1'b1;
    @(negedge clk); mrst = 1'b0;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd("R1 ctl2", 3'd4, 8'h09);
    rd("R1 ctl1", 3'd3, 8'h00);
    rd("R1 asec", 3'd0, 8'h00);
    rd("R1 ahr", 3'd2, 8'h00);
    chk("R1 run", {6'b0, cnt_en, start}, 8'h03);
    chk("R1 irq", {6'b0, alm_irq, per_irq}, 8'h00);

    // R2/R3 sweep: enable mask x per-field match pattern
    for (int mask = 0; mask < 8; mask++) begin
      wr(3'd0, {mask[0], 7'd10});
      wr(3'd1, {mask[1], 7'd20});
      wr(3'd2, {mask[2], 1'b0, 6'd5});
      for (int pat = 0; pat < 8; pat++) begin
        logic exp_af;
        exp_af = (mask != 0) && ((pat & mask) == mask);
        upd(pat[0] ? 7'd10 : 7'd11, pat[1] ? 7'd20 : 7'd21, pat[2] ? 6'd5 : 6'd6);
        rd(mask == 0 ? "R3 no enable" : "R2 match", 3'd3, {7'b0, exp_af});
        wr(3'd3, 8'h00);
      end
    end

    // R3 matching counts without an update
    sec = 7'd10; min = 7'd20; hr = 6'd5;
    repeat (4) @(negedge clk);
    rd("R3 no update", 3'd3, 8'h00);

    // R4 write 1 keeps, write 0 clears, set beats clear
    upd(7'd10, 7'd20, 6'd5);
    wr(3'd3, 8'h01);
    rd("R4 write1 keep", 3'd3, 8'h01);
    wr(3'd3, 8'h00);
    rd("R4 write0 clear", 3'd3, 8'h00);
    @(negedge clk); sec_upd = 1'b1; addr = 3'd3; wdata = 8'h00; we = 1'b1;
    @(negedge clk); sec_upd = 1'b0; we = 1'b0;
    rd("R4 collision", 3'd3, 8'h01);

    // R5 interrupt gating
    chk("R5 aie0", {7'b0, alm_irq}, 8'h00);
    wr(3'd3, 8'h09);
    chk("R5 both", {7'b0, alm_irq}, 8'h01);
    wr(3'd3, 8'h08);
    chk("R5 af0", {7'b0, alm_irq}, 8'h00);
    wr(3'd3, 8'h00);

    // R6/R7 sweep: tick select x tick line
    for (int code = 0; code < 8; code++) begin
      for (int idx = 0; idx < 7; idx++) begin
        logic exp_p;
        wr(3'd4, 8'((code << 4) | 9));
        tk(idx);
        exp_p = (code != 0) && (idx == code - 1);
        chk("R7 per_irq", {7'b0, per_irq}, {7'b0, exp_p});
        rd("R6 ctl2 image", 3'd4, 8'({exp_p, 7'b0} | (code << 4) | 9));
      end
    end
    wr(3'd4, 8'h19);
    chk("R7 cleared", {7'b0, per_irq}, 8'h00);
    wr(3'd4, 8'h99);
    chk("R7 write1 no set", {7'b0, per_irq}, 8'h00);
    tk(0);
    wr(3'd4, 8'h99);
    chk("R7 write1 keep", {7'b0, per_irq}, 8'h01);

    // R6 run bits
    wr(3'd4, 8'h00);
    chk("R6 run 00", {6'b0, cnt_en, start}, 8'h00);
    wr(3'd4, 8'h08);
    chk("R6 run 10", {6'b0, cnt_en, start}, 8'h02);
    wr(3'd4, 8'h01);
    chk("R6 run 01", {6'b0, cnt_en, start}, 8'h01);

    // R8 adjust strobe
    wr(3'd4, 8'h0D);
    chk("R8 adj pulse", {7'b0, adj}, 8'h01);
    @(negedge clk);
    chk("R8 adj end", {7'b0, adj}, 8'h00);
    rd("R8 readback", 3'd4, 8'h09);

    // R9 divider reset strobe
    wr(3'd4, 8'h0B);
    chk("R9 div pulse", {7'b0, div_rst}, 8'h01);
    @(negedge clk);
    chk("R9 div end", {7'b0, div_rst}, 8'h00);
    rd("R9 readback", 3'd4, 8'h09);

    // R10 manual reset
    wr(3'd0, 8'h8A);
    wr(3'd4, 8'h58);
    tk(4);
    upd(7'd10, 7'd0, 6'd0);
    wr(3'd3, 8'h09);
    rd("R10 pre", 3'd4, 8'hD8);
    mpulse();
    rd("R10 ctl2", 3'd4, 8'h08);
    rd("R10 ctl1", 3'd3, 8'h00);
    rd("R10 alarm kept", 3'd0, 8'h8A);

    // R11 standby hold
    wr(3'd4, 8'h19);
    @(negedge clk); stby = 1'b1;
    wr(3'd4, 8'h00);
    tk(0);
    mpulse();
    rd("R11 hold", 3'd4, 8'h19);
    chk("R11 no irq", {7'b0, per_irq}, 8'h00);
    @(negedge clk); stby = 1'b0;
    tk(0);
    rd("R11 resume", 3'd4, 8'h99);

    finish_run();
  end
endmodule